// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block steers a processor into a trap or interrupt handler. On any cycle in which it is idle, it examines three kinds of request: a software break carrying its own trap number, an address-translation miss, and a 32-bit vector of pending external interrupts. It picks one cause and derives a vector number from it. It then reads the handler address from a vector table in memory through a simple read port. When the read data returns, it commits three values together: the new program counter, the return address, and the rewritten status word.

The status word is not saved to memory. Instead, a fixed bit-field shift pushes the flag history one level deep: the top two bits stay in place, the low twenty bits move up by ten places, and the bottom ten bits are cleared. The return address depends on the cause. A break resumes after its two-byte instruction. A translation miss and an external interrupt resume at the current program counter, so the faulting instruction runs again.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The memory read address equals `vec_base` plus four times the chosen vector number.
- R2: For a software break, the vector number is `brk_trap`, and `ret_pc` is `cur_pc` + 2.
- R3: For a translation miss, the vector number is 4, and `ret_pc` equals `cur_pc`.
- R4: For an external interrupt, the vector number is 0x30 plus the index of the highest set bit of `irq_pend`, and `ret_pc` equals `cur_pc`.
- R5: An external interrupt starts an entry only when `irq_pend` is nonzero and bit 8 of `cur_stat` (interrupt enable) is 1. Otherwise no read is issued, and `new_pc`, `ret_pc` and `new_stat` keep their values.
- R6: On every entry, `new_stat` keeps bits 31:30 of `cur_stat`, places `cur_stat[19:0]` in bits 29:10, and sets bits 9:0 to zero.
- R7: In the cycle `done` is high, `new_pc` equals the read data that was returned.
- R8: When causes coincide, a break wins over a miss, and a miss wins over an external interrupt.
- R9: `rd_valid` holds with a stable address until `rd_ready` is seen. The outputs commit only after `rd_resp_valid`, and `done` is a one-cycle pulse.
- R10: Requests that arrive while an entry is in progress are ignored. Once the block is idle again, no new read appears unless a request is still present.
- R11: After reset, `rd_valid` and `done` are low, and `new_pc`, `ret_pc` and `new_stat` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_req | input | 1 | Software break request |
| brk_trap | input | 8 | Trap number of the break |
| miss_req | input | 1 | Address-translation miss request |
| irq_pend | input | 32 | Pending external interrupt lines |
| cur_pc | input | 32 | Current program counter |
| cur_stat | input | 32 | Current status word |
| vec_base | input | 32 | Vector table base address |
| rd_valid | output | 1 | Vector read request valid |
| rd_addr | output | 32 | Vector read address |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data (handler address) |
| done | output | 1 | One-cycle entry completion pulse |
| new_pc | output | 32 | Committed handler program counter |
| ret_pc | output | 32 | Committed return address |
| new_stat | output | 32 | Committed shifted status word |

## Verification
Two things can happen in the same cycle: different causes can be requested together, and a new request can arrive while an entry is still in progress. The bench drives a break, a miss and a nonzero interrupt vector in every combination, all on the same idle cycle. It judges the winner by the read address and by the committed return address. It also raises a break while the block waits for read data, then checks that the request is dropped and no second read follows the done pulse. Around these cases, the bench sweeps every trap number and every single interrupt line, computing the expected address and status word arithmetically.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} entry_st_e;
   typedef enum logic [1:0] {CS_NONE, CS_BRK, CS_MISS, CS_IRQ} cause_e;
endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
   import exc_entry_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IRQ_W    = 32,
   parameter int VEC_W    = 8,
   parameter int IE_BIT   = 8,
   parameter int IRQ_BASE = 'h30,
   parameter int MISS_VEC = 4
) (
   input  logic             brk_req,
   input  logic [VEC_W-1:0] brk_trap,
   input  logic             miss_req,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic [XLEN-1:0]  stat,
   output cause_e           cause,
   output logic [VEC_W-1:0] vec
);
   localparam int IDX_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;

   if (IE_BIT >= XLEN) begin : g_bad_ie
      $error("IE_BIT outside status word");
   end
   if (IRQ_BASE + IRQ_W > (1 << VEC_W)) begin : g_bad_vw
      $error("VEC_W too narrow for interrupt vectors");
   end

   logic [IDX_W-1:0] hi_idx;
   logic             irq_ok;

   always_comb begin
      hi_idx = '0;
      for (int i = 0; i < IRQ_W; i++) begin
         if (irq_pend[i]) hi_idx = IDX_W'(i);
      end
   end

   assign irq_ok = (|irq_pend) && stat[IE_BIT];

   always_comb begin
      cause = CS_NONE;
      vec   = '0;
      if (brk_req) begin
         cause = CS_BRK;
         vec   = brk_trap;
      end else if (miss_req) begin
         cause = CS_MISS;
         vec   = VEC_W'(MISS_VEC);
      end else if (irq_ok) begin
         cause = CS_IRQ;
         vec   = VEC_W'(IRQ_BASE) + VEC_W'(hi_idx);
      end
   end
endmodule

// File: rtl/exc_flag_push.sv
module exc_flag_push #(
   parameter int XLEN  = 32,
   parameter int KEEP  = 2,
   parameter int SHIFT = 10
) (
   input  logic [XLEN-1:0] stat_in,
   output logic [XLEN-1:0] stat_out
);
   localparam int MOVE = XLEN - KEEP - SHIFT;

   if (KEEP < 1 || MOVE < 1) begin : g_bad_geom
      $error("status shift geometry invalid");
   end

   if (SHIFT == 0) begin : g_pass
      assign stat_out = stat_in;
   end else begin : g_shift
      assign stat_out = {stat_in[XLEN-1 -: KEEP], stat_in[MOVE-1:0], {SHIFT{1'b0}}};
   end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
   parameter int XLEN   = 32,
   parameter int VEC_W  = 8,
   parameter int STRIDE = 4
) (
   input  logic [XLEN-1:0]  base,
   input  logic [VEC_W-1:0] vec,
   output logic [XLEN-1:0]  addr
);
   localparam bit POW2 = (STRIDE > 0) && ((STRIDE & (STRIDE - 1)) == 0);
   localparam int SH   = (STRIDE > 1) ? $clog2(STRIDE) : 0;

   if (STRIDE < 1) begin : g_bad_stride
      $error("STRIDE must be positive");
   end

   if (POW2) begin : g_shift
      assign addr = base + (XLEN'(vec) << SH);
   end else begin : g_mul
      assign addr = base + XLEN'(vec) * XLEN'(STRIDE);
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IRQ_W    = 32,
   parameter int VEC_W    = 8,
   parameter int IE_BIT   = 8,
   parameter int IRQ_BASE = 'h30,
   parameter int MISS_VEC = 4,
   parameter int BRK_OFS  = 2,
   parameter int STRIDE   = 4,
   parameter int KEEP     = 2,
   parameter int SHIFT    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             brk_req,
   input  logic [VEC_W-1:0] brk_trap,
   input  logic             miss_req,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [XLEN-1:0]  cur_stat,
   input  logic [XLEN-1:0]  vec_base,
   output logic             rd_valid,
   output logic [XLEN-1:0]  rd_addr,
   input  logic             rd_ready,
   input  logic             rd_resp_valid,
   input  logic [XLEN-1:0]  rd_resp_data,
   output logic             done,
   output logic [XLEN-1:0]  new_pc,
   output logic [XLEN-1:0]  ret_pc,
   output logic [XLEN-1:0]  new_stat
);
   entry_st_e        st_q;
   cause_e           cause;
   logic [VEC_W-1:0] vec;
   logic [XLEN-1:0]  addr_c, stat_c, ret_c;
   logic [XLEN-1:0]  addr_q, ret_stage_q, stat_stage_q;

   exc_cause_sel #(
      .XLEN(XLEN), .IRQ_W(IRQ_W), .VEC_W(VEC_W), .IE_BIT(IE_BIT),
      .IRQ_BASE(IRQ_BASE), .MISS_VEC(MISS_VEC)
   ) u_sel (
      .brk_req(brk_req), .brk_trap(brk_trap), .miss_req(miss_req),
      .irq_pend(irq_pend), .stat(cur_stat), .cause(cause), .vec(vec)
   );

   exc_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W), .STRIDE(STRIDE)) u_addr (
      .base(vec_base), .vec(vec), .addr(addr_c)
   );

   exc_flag_push #(.XLEN(XLEN), .KEEP(KEEP), .SHIFT(SHIFT)) u_push (
      .stat_in(cur_stat), .stat_out(stat_c)
   );

   assign ret_c = (cause == CS_BRK) ? cur_pc + XLEN'(BRK_OFS) : cur_pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         addr_q       <= '0;
         ret_stage_q  <= '0;
         stat_stage_q <= '0;
         new_pc       <= '0;
         ret_pc       <= '0;
         new_stat     <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cause != CS_NONE) begin
               st_q         <= ST_REQ;
               addr_q       <= addr_c;
               ret_stage_q  <= ret_c;
               stat_stage_q <= stat_c;
            end
            ST_REQ: if (rd_ready) st_q <= ST_WAIT;
            ST_WAIT: if (rd_resp_valid) begin
               st_q     <= ST_DONE;
               new_pc   <= rd_resp_data;
               ret_pc   <= ret_stage_q;
               new_stat <= stat_stage_q;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_valid = (st_q == ST_REQ);
   assign rd_addr  = addr_q;
   assign done     = (st_q == ST_DONE);
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int XLEN   = 32,
   parameter int IRQ_W  = 32,
   parameter int IE_BIT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             brk_req,
   input logic             miss_req,
   input logic [IRQ_W-1:0] irq_pend,
   input logic [XLEN-1:0]  cur_stat,
   input logic             rd_valid,
   input logic [XLEN-1:0]  rd_addr,
   input logic             rd_ready,
   input logic             rd_resp_data_dummy,
   input logic [XLEN-1:0]  rd_resp_data,
   input logic             done,
   input logic [XLEN-1:0]  new_pc
);
   // R9
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   commit_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (new_pc == $past(rd_resp_data)));
   // R5
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(brk_req || miss_req ||
                                ((|irq_pend) && cur_stat[IE_BIT])));
   // R10
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_valid);
   // R9
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> !rd_valid);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .IRQ_W(IRQ_W), .IE_BIT(IE_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .miss_req(miss_req),
   .irq_pend(irq_pend), .cur_stat(cur_stat), .rd_valid(rd_valid),
   .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_resp_data_dummy(rd_resp_valid),
   .rd_resp_data(rd_resp_data), .done(done), .new_pc(new_pc)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        brk_req = 1'b0;
   logic [7:0]  brk_trap = '0;
   logic        miss_req = 1'b0;
   logic [31:0] irq_pend = '0;
   logic [31:0] cur_pc = '0;
   logic [31:0] cur_stat = '0;
   logic [31:0] vec_base = '0;
   logic        rd_valid;
   logic [31:0] rd_addr;
   logic        rd_ready = 1'b0;
   logic        rd_resp_valid = 1'b0;
   logic [31:0] rd_resp_data = '0;
   logic        done;
   logic [31:0] new_pc, ret_pc, new_stat;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   exc_entry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .brk_trap(brk_trap),
      .miss_req(miss_req), .irq_pend(irq_pend), .cur_pc(cur_pc),
      .cur_stat(cur_stat), .vec_base(vec_base), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid),
      .rd_resp_data(rd_resp_data), .done(done), .new_pc(new_pc),
      .ret_pc(ret_pc), .new_stat(new_stat)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] push_stat(input logic [31:0] s);
      return (s & 32'hC000_0000) | ((s << 12) >> 2);
   endfunction

   function automatic int top_bit(input logic [31:0] p);
      int r = -1;
      for (int i = 0; i < 32; i++) if (p[i]) r = i;
      return r;
   endfunction

   // Runs one entry; expects a read at vec_base + 4*exp_vec.
   task automatic run_entry(input logic b, input logic [7:0] t, input logic m,
                            input logic [31:0] p, input logic [31:0] s,
                            input logic [31:0] pc, input logic [31:0] vb,
                            input int exp_vec, input logic [31:0] exp_ret,
                            input string req, input bit intrude);
      logic [31:0] hnd;
      int wait_n;
      hnd = (32'(exp_vec) * 32'h0101_0107) ^ pc;
      brk_req = b; brk_trap = t; miss_req = m; irq_pend = p;
      cur_stat = s; cur_pc = pc; vec_base = vb;
      wait_n = 0;
      @(negedge clk);
      while (!rd_valid && wait_n < 8) begin
         @(negedge clk);
         wait_n++;
      end
      // R1: address
      chk(rd_valid && rd_addr == vb + 32'(exp_vec) * 4, {req, "/R1"}, rd_addr,
          vb + 32'(exp_vec) * 4);
      brk_req = 1'b0; miss_req = 1'b0; irq_pend = '0;
      // R9: held until ready
      @(negedge clk);
      chk(rd_valid && !done, "R9 hold", {31'd0, rd_valid}, 32'd1);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk(!rd_valid && !done, "R9 wait", {31'd0, done}, 32'd0);
      rd_resp_valid = 1'b1; rd_resp_data = hnd;
      if (intrude) brk_req = 1'b1;
      @(negedge clk);
      rd_resp_valid = 1'b0;
      brk_req = 1'b0;
      chk(done == 1'b1, "R9 done", {31'd0, done}, 32'd1);
      chk(new_pc == hnd, "R7", new_pc, hnd);
      chk(ret_pc == exp_ret, req, ret_pc, exp_ret);
      chk(new_stat == push_stat(s), "R6", new_stat, push_stat(s));
      @(negedge clk);
      chk(!done, "R9 pulse", {31'd0, done}, 32'd0);
      if (intrude) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!rd_valid && new_pc == hnd, "R10", {31'd0, rd_valid}, 32'd0);
         end
      end
   endtask

   initial begin
      logic [31:0] hold_pc;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!rd_valid && !done && new_pc == 0 && ret_pc == 0 && new_stat == 0,
          "R11", new_pc, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 sweep of every trap number
      for (int t = 0; t < 256; t++)
         run_entry(1'b1, 8'(t), 1'b0, '0, 32'hA5A5_0000 ^ 32'(t * 977),
                   32'h100 + 32'(t * 6), 32'h4000_0000 + 32'(t * 64),
                   t, 32'h102 + 32'(t * 6), "R2", 1'b0);

      // R3 miss
      run_entry(1'b0, 8'h0, 1'b1, '0, 32'hFFFF_FFFF, 32'h0000_8000,
                32'h2000_0000, 4, 32'h0000_8000, "R3", 1'b0);

      // R4 each line, with lower lines set as well
      for (int b = 0; b < 32; b++)
         run_entry(1'b0, 8'h0, 1'b0, (32'd1 << b) | (32'd1 << (b / 2)),
                   32'h0000_0100 | 32'(b * 32'h0001_1000), 32'h3000 + 32'(b * 4),
                   32'h0010_0000, 'h30 + b, 32'h3000 + 32'(b * 4), "R4", 1'b0);

      // R5 enable clear, then zero pending with enable set
      hold_pc = new_pc;
      irq_pend = 32'h8000_0001; cur_stat = 32'hFFFF_FEFF;
      repeat (4) begin
         @(negedge clk);
         chk(!rd_valid && !done && new_pc == hold_pc, "R5 masked",
             {31'd0, rd_valid}, 32'd0);
      end
      irq_pend = '0; cur_stat = 32'h0000_0100;
      repeat (4) begin
         @(negedge clk);
         chk(!rd_valid && !done && new_pc == hold_pc, "R5 empty",
             {31'd0, rd_valid}, 32'd0);
      end

      // R8 coincident causes
      run_entry(1'b1, 8'h21, 1'b1, 32'h10, 32'h100, 32'h500, 32'h800, 'h21,
                32'h502, "R8 brk+miss+irq", 1'b0);
      run_entry(1'b1, 8'h07, 1'b1, '0, 32'h0, 32'h600, 32'h800, 'h07,
                32'h602, "R8 brk+miss", 1'b0);
      run_entry(1'b0, 8'h07, 1'b1, 32'h4000_0000, 32'h100, 32'h700, 32'h800, 4,
                32'h700, "R8 miss+irq", 1'b0);
      run_entry(1'b1, 8'h99, 1'b0, 32'h1, 32'h100, 32'h900, 32'h800, 'h99,
                32'h902, "R8 brk+irq", 1'b0);

      // R10 request during the wait is dropped
      run_entry(1'b0, 8'h0, 1'b1, '0, 32'h1234_5678, 32'hA00, 32'h0, 4,
                32'hA00, "R10 entry", 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule